// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block turns a one-cycle master-clock tick into the two timing clocks that a stereo serial audio port needs. One is a bit clock derived from the master tick by a ratio of two or four. The other is a left/right frame clock derived from the bit clock by a ratio of 32, 64 or 128 bit-clock periods. Both are produced as square-wave levels and, alongside them, as single-cycle tick strobes that downstream shift logic can use as clock enables. Everything runs in the system clock domain: the master clock enters as an enable pulse, not as a clock.

A four-bit control word is written through a simple write port. It holds one enable bit that starts and stops both clocks together, a bit-clock divide select and a frame-ratio select. When the generator is stopped, both clocks rest low and all counters clear. When it starts, it begins with a full left-channel half frame. While it runs, changes to either select wait for the next frame boundary, so a frame in progress is never shortened or stretched.

Top module: `sclk_gen`

## Requirements
- R1: After reset the control word is zero (stopped) and `bclk`, `fclk`, `bclk_tick` and `fclk_tick` are all low.
- R2: With control bit 1 clear, `bclk` changes level once per master tick, giving a bit clock of the master rate divided by 2.
- R3: With control bit 1 set, `bclk` changes level once every second master tick, giving the master rate divided by 4.
- R4: Control bits 3:2 select the frame ratio: 00 gives 32, 01 gives 64 and 10 gives 128 bit-clock periods per frame; each half of the frame lasts half that many bit-clock periods.
- R5: `fclk` changes level only in the cycle in which `bclk` falls.
- R6: A write whose bits 3:2 are 11 is discarded as a whole; enable and both selects keep their previous values.
- R7: Control bit 0 is the enable. While it is clear, both clocks and both tick strobes are low from the following cycle on; once set, the generator starts from the beginning of a left half (fclk low) and the first `fclk` change is to high after one full half frame.
- R8: A change of either select written while running takes effect only at the next frame boundary (the falling edge of `fclk`); the frame in progress completes with the old settings.
- R9: `bclk_tick` is high for exactly one cycle, in the cycle `bclk` has just fallen; `fclk_tick` is high for exactly one cycle, in each cycle `fclk` has just changed level.
- R10: In a cycle following a cycle without a master tick, neither `bclk` nor `fclk` changes level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | Control word: bit 0 enable, bit 1 bit-clock divide by 4, bits 3:2 frame ratio |
| mclk_tick | input | 1 | One-cycle master clock enable |
| bclk | output | 1 | Bit clock square wave |
| bclk_tick | output | 1 | One-cycle strobe on each bit-clock falling edge |
| fclk | output | 1 | Frame clock square wave, low for the left channel |
| fclk_tick | output | 1 | One-cycle strobe on each frame-clock level change |

## Verification
Two events can coincide in one cycle: a control write landing in the register and a frame boundary that loads the pending selects, and likewise a disable arriving in the same cycle as a bit-clock or frame-clock edge. Random writes, including rejected ratio codes and enable toggles, are issued at random moments under a random master-tick density, so these collisions happen many times. A cycle-level model in the bench, which applies the boundary load from the control value held before the write, judges every cycle's clock and strobe levels, while directed runs measure half-frame lengths in bit-clock falls across each boundary.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    // Frame ratio select codes (control bits 3:2)
    typedef enum logic [1:0] {
        FR_32  = 2'b00,
        FR_64  = 2'b01,
        FR_128 = 2'b10,
        FR_BAD = 2'b11
    } frame_ratio_e;

    // Control word, packed so that its bit layout equals the write data layout
    typedef struct packed {
        frame_ratio_e ratio;   // bits 3:2
        logic         bdiv4;   // bit 1
        logic         en;      // bit 0
    } sclk_ctrl_t;

    localparam int CTRL_W = $bits(sclk_ctrl_t);

endpackage

// File: rtl/sclk_ctrl_reg.sv
module sclk_ctrl_reg
    import sclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output sclk_ctrl_t        ctrl
);

    sclk_ctrl_t ctrl_d, ctrl_q;
    sclk_ctrl_t wr_word;

    always_comb begin
        wr_word = sclk_ctrl_t'(wr_data);
        ctrl_d  = ctrl_q;
        // A reserved ratio code rejects the whole word
        if (wr_en && (wr_word.ratio != FR_BAD)) begin
            ctrl_d = wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/sclk_sel_track.sv
module sclk_sel_track
    import sclk_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  sclk_ctrl_t   ctrl,
    input  logic         frame_start,
    output logic         eff_bdiv4,
    output frame_ratio_e eff_ratio
);

    typedef struct packed {
        logic         run;
        logic         bdiv4;
        frame_ratio_e ratio;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        // Settings in force: the control word until running, then the latched copy
        eff_bdiv4 = st_q.run ? st_q.bdiv4 : ctrl.bdiv4;
        eff_ratio = st_q.run ? st_q.ratio : ctrl.ratio;

        st_d = st_q;
        if (!ctrl.en) begin
            st_d.run   = 1'b0;
            st_d.bdiv4 = ctrl.bdiv4;
            st_d.ratio = ctrl.ratio;
        end else begin
            st_d.run   = 1'b1;
            st_d.bdiv4 = eff_bdiv4;
            st_d.ratio = eff_ratio;
            if (frame_start) begin
                st_d.bdiv4 = ctrl.bdiv4;
                st_d.ratio = ctrl.ratio;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sclk_bit_div.sv
module sclk_bit_div #(
    parameter int DIV_LO = 2,
    parameter int DIV_HI = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mclk_tick,
    input  logic bdiv4,
    output logic bclk,
    output logic bclk_tick,
    output logic bfall
);

    localparam int HALF_LO = DIV_LO / 2;
    localparam int HALF_HI = DIV_HI / 2;
    localparam int CNT_W   = (HALF_HI > 1) ? $clog2(HALF_HI) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
        logic             tick;
    } bdiv_t;

    bdiv_t            st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = bdiv4 ? CNT_W'(HALF_HI - 1) : CNT_W'(HALF_LO - 1);
        st_d      = st_q;
        st_d.tick = 1'b0;
        bfall     = 1'b0;
        if (!en) begin
            st_d = '0;
        end else if (mclk_tick) begin
            if (st_q.cnt >= limit) begin
                st_d.cnt = '0;
                st_d.lvl = ~st_q.lvl;
                if (st_q.lvl) begin
                    bfall     = 1'b1;
                    st_d.tick = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk      = st_q.lvl;
    assign bclk_tick = st_q.tick;

endmodule

// File: rtl/sclk_frame_div.sv
module sclk_frame_div
    import sclk_pkg::*;
#(
    parameter int FRAME_BASE = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         bfall,
    input  frame_ratio_e ratio,
    output logic         fclk,
    output logic         fclk_tick,
    output logic         frame_start
);

    localparam int HALF_BASE = FRAME_BASE / 2;
    localparam int CNT_W     = $clog2(4 * HALF_BASE);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
        logic             tick;
    } fdiv_t;

    fdiv_t            st_d, st_q;
    logic [CNT_W-1:0] limit;

    function automatic logic [CNT_W-1:0] half_last(input frame_ratio_e r);
        case (r)
            FR_64:   half_last = CNT_W'(2 * HALF_BASE - 1);
            FR_128:  half_last = CNT_W'(4 * HALF_BASE - 1);
            default: half_last = CNT_W'(HALF_BASE - 1);
        endcase
    endfunction

    always_comb begin
        limit       = half_last(ratio);
        st_d        = st_q;
        st_d.tick   = 1'b0;
        frame_start = 1'b0;
        if (!en) begin
            st_d = '0;
        end else if (bfall) begin
            if (st_q.cnt >= limit) begin
                st_d.cnt  = '0;
                st_d.lvl  = ~st_q.lvl;
                st_d.tick = 1'b1;
                // Leaving the right half starts a new frame
                frame_start = st_q.lvl;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fclk      = st_q.lvl;
    assign fclk_tick = st_q.tick;

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
    import sclk_pkg::*;
#(
    parameter int BCLK_DIV_LO = 2,
    parameter int BCLK_DIV_HI = 4,
    parameter int FRAME_BASE  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              mclk_tick,
    output logic              bclk,
    output logic              bclk_tick,
    output logic              fclk,
    output logic              fclk_tick
);

    sclk_ctrl_t   ctrl;
    logic         ctrl_en;
    logic         eff_bdiv4;
    frame_ratio_e eff_ratio;
    logic         bfall;
    logic         frame_start;

    assign ctrl_en = ctrl.en;

    sclk_ctrl_reg i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .ctrl    (ctrl)
    );

    sclk_sel_track i_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl        (ctrl),
        .frame_start (frame_start),
        .eff_bdiv4   (eff_bdiv4),
        .eff_ratio   (eff_ratio)
    );

    sclk_bit_div #(
        .DIV_LO (BCLK_DIV_LO),
        .DIV_HI (BCLK_DIV_HI)
    ) i_bdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_en),
        .mclk_tick (mclk_tick),
        .bdiv4     (eff_bdiv4),
        .bclk      (bclk),
        .bclk_tick (bclk_tick),
        .bfall     (bfall)
    );

    sclk_frame_div #(
        .FRAME_BASE (FRAME_BASE)
    ) i_fdiv (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctrl_en),
        .bfall       (bfall),
        .ratio       (eff_ratio),
        .fclk        (fclk),
        .fclk_tick   (fclk_tick),
        .frame_start (frame_start)
    );

endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic mclk_tick,
    input logic ctrl_en,
    input logic bclk,
    input logic bclk_tick,
    input logic fclk,
    input logic fclk_tick
);

    // R5: a frame clock edge while running always rides on a bit clock fall
    p_fclk_on_bfall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fclk) && $past(ctrl_en)) |-> (bclk_tick && !bclk));

    // R9: bit tick marks a fall and never lasts two cycles
    p_btick_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_tick |-> !bclk);
    p_btick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_tick |=> !bclk_tick);

    // R9: frame tick only with a frame clock level change
    p_ftick_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fclk_tick |-> !$stable(fclk));

    // R7: stopped generator keeps everything low
    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl_en) |-> (!bclk && !fclk && !bclk_tick && !fclk_tick));

    // R10: no master tick, no clock movement
    p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mclk_tick) && $past(ctrl_en)) |-> ($stable(bclk) && $stable(fclk)));

    // R2: a bit clock edge while running needs a master tick
    p_bclk_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bclk) && $past(ctrl_en)) |-> $past(mclk_tick));

endmodule

bind sclk_gen sclk_gen_chk i_sclk_gen_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclk_tick (mclk_tick),
    .ctrl_en   (ctrl_en),
    .bclk      (bclk),
    .bclk_tick (bclk_tick),
    .fclk      (fclk),
    .fclk_tick (fclk_tick)
);

// File: tb/test_sclk_gen.sv
`timescale 1ns/1ps
module test_sclk_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = 4'h0;
    logic       mclk_tick = 1'b0;
    logic       bclk, bclk_tick, fclk, fclk_tick;

    int checks = 0;
    int errors = 0;
    int tick_pct = 100;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sclk_gen i_sclk_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .mclk_tick (mclk_tick),
        .bclk      (bclk),
        .bclk_tick (bclk_tick),
        .fclk      (fclk),
        .fclk_tick (fclk_tick)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic       cap_rst = 1'b0, cap_we = 1'b0, cap_tick = 1'b0;
    logic [3:0] cap_wd = 4'h0;
    bit   m_en, m_cb, m_run, m_ab, m_bclk, m_fclk, m_btk, m_ftk;
    logic [1:0] m_cf, m_af;
    int   m_mc, m_bc;
    int   falls = 0, last_half = 0, half_cnt = 0, viol = 0;

    function automatic int half_len(input logic [1:0] r);
        return 16 << r;
    endfunction

    always @(posedge clk) begin
        cap_rst  = rst_n;
        cap_we   = cfg_we;
        cap_wd   = cfg_wdata;
        cap_tick = mclk_tick;
    end

    always @(negedge clk) begin
        bit eb;
        logic [1:0] ef;
        if (!cap_rst) begin
            m_en = 0; m_cb = 0; m_cf = 2'b00; m_run = 0; m_ab = 0; m_af = 2'b00;
            m_mc = 0; m_bc = 0; m_bclk = 0; m_fclk = 0; m_btk = 0; m_ftk = 0;
        end else begin
            m_btk = 0; m_ftk = 0;
            if (!m_en) begin
                m_run = 0; m_mc = 0; m_bc = 0; m_bclk = 0; m_fclk = 0;
                m_ab = m_cb; m_af = m_cf;
            end else begin
                eb = m_run ? m_ab : m_cb;
                ef = m_run ? m_af : m_cf;
                m_run = 1; m_ab = eb; m_af = ef;
                if (cap_tick) begin
                    if (m_mc + 1 >= (eb ? 2 : 1)) begin
                        m_mc = 0;
                        if (m_bclk) begin
                            m_bclk = 0; m_btk = 1; m_bc++;
                            if (m_bc == half_len(ef)) begin
                                m_bc = 0; m_fclk = ~m_fclk; m_ftk = 1;
                                if (!m_fclk) begin m_ab = m_cb; m_af = m_cf; end
                            end
                        end else begin
                            m_bclk = 1;
                        end
                    end else begin
                        m_mc++;
                    end
                end
            end
            if (cap_we && cap_wd[3:2] != 2'b11) {m_cf, m_cb, m_en} = cap_wd;
        end
        if (rst_n) begin
            chk(bclk == m_bclk, m_ab ? "R3" : "R2", "bclk", bclk, m_bclk);
            chk(fclk == m_fclk, "R4", "fclk", fclk, m_fclk);
            chk(bclk_tick == m_btk, "R9", "bclk_tick", bclk_tick, m_btk);
            chk(fclk_tick == m_ftk, "R9", "fclk_tick", fclk_tick, m_ftk);
            if (fclk_tick && !bclk_tick) viol++;
            if (bclk_tick) falls++;
            if (fclk_tick) begin last_half = falls; falls = 0; half_cnt++; end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc();
        mclk_tick = ($urandom_range(99) < tick_pct);
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic wait_frame_start();
        do cyc(); while (!(fclk_tick && !fclk));
    endtask

    task automatic wait_halves(input int n);
        int s = half_cnt;
        while (half_cnt < s + n) cyc();
    endtask

    task automatic count_toggles(input int n, output int tog, output int btk);
        logic p;
        tog = 0; btk = 0;
        for (int i = 0; i < n; i++) begin
            p = bclk;
            cyc();
            if (bclk != p) tog++;
            if (bclk_tick) btk++;
        end
    endtask

    initial begin
        #720000;
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int tog, btk;
        logic hb, hf;
        void'($urandom(32'h00c0ffee));
        tick_pct = 100;
        repeat (4) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk(!bclk && !fclk && !bclk_tick && !fclk_tick, "R1", "outputs after reset",
            {bclk, fclk, bclk_tick, fclk_tick}, 0);

        // R2 divide by 2, ratio 32
        wr(4'b0001);
        cyc();
        count_toggles(8, tog, btk);
        chk(tog == 8, "R2", "bclk toggles in 8 ticks", tog, 8);
        chk(btk == 4, "R9", "bclk_tick pulses in 8 ticks", btk, 4);
        wait_halves(2);
        chk(last_half == 16, "R4", "half frame ratio 32", last_half, 16);

        // R8 ratio 64 written mid-frame
        wr(4'b0101);
        wait_frame_start();
        chk(last_half == 16, "R8", "half before boundary keeps old ratio", last_half, 16);
        wait_halves(1);
        chk(last_half == 32, "R8", "half after boundary uses ratio 64", last_half, 32);

        // R3 divide by 4
        wr(4'b0111);
        wait_frame_start();
        count_toggles(8, tog, btk);
        chk(tog == 4, "R3", "bclk toggles in 8 ticks", tog, 4);

        // R4 ratio 128
        wr(4'b1001);
        wait_frame_start();
        wait_halves(1);
        chk(last_half == 64, "R4", "half frame ratio 128", last_half, 64);

        // R6 reserved ratio write with enable clear is dropped
        wr(4'b1100);
        count_toggles(4, tog, btk);
        chk(tog == 4, "R6", "still running after rejected write", tog, 4);
        wait_halves(2);
        chk(last_half == 64, "R6", "ratio unchanged after rejected write", last_half, 64);

        // R10 no master ticks
        tick_pct = 0;
        cyc();
        hb = bclk; hf = fclk; tog = 0;
        for (int i = 0; i < 10; i++) begin
            cyc();
            if (bclk != hb || fclk != hf || bclk_tick || fclk_tick) tog++;
        end
        chk(tog == 0, "R10", "changes without master tick", tog, 0);
        tick_pct = 100;

        // R7 disable then restart
        wr(4'b0000);
        cyc();
        chk(!bclk && !fclk && !bclk_tick && !fclk_tick, "R7", "outputs while disabled",
            {bclk, fclk, bclk_tick, fclk_tick}, 0);
        falls = 0;
        wr(4'b0001);
        wait_halves(1);
        chk(fclk == 1'b1, "R7", "first frame clock edge rises", fclk, 1);
        chk(last_half == 16, "R7", "first half frame full length", last_half, 16);

        // Random phase: random tick density, random writes
        for (int seg = 0; seg < 60; seg++) begin
            tick_pct = 20 + $urandom_range(80);
            for (int i = 0; i < 300; i++) begin
                if ($urandom_range(149) == 0) begin
                    wr(4'($urandom_range(15)));
                end else begin
                    cyc();
                end
            end
        end

        chk(viol == 0, "R5", "frame ticks without bit fall", viol, 0);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule